// File: doc/BRIEF.md
# Core Power-Down Sequencer

This block shuts down one secondary CPU core power domain at a time. It keeps a 7-bit power-control word and a cache power-down request for every core. When a start request names a valid core, it changes that core's word one bit per cycle in a fixed order. Midway through, it raises the core's cache power-down request and waits for the acknowledge. At the end it waits until both power-status feedback vectors report that core's rail as off. It then emits a one-cycle done pulse and returns to idle.

Core 0 is the boot core and can never be selected. A start that names core 0, or that arrives while a sequence is running, is dropped. Each control word stays in the state the sequence left it in until the next reset. Reset puts every core in the powered state.

Top module: `core_pdn_seq`

## Requirements
- R1: After reset every core's control word is 0x4D: bit0 reset-bar=1, bit1 isolation=0, bit2 primary switch=1, bit3 secondary switch=1, bit4 clock-off=0, bit5 SRAM clock isolation=0, bit6 SRAM isolation-bar=1. All cache requests, `busy_o` and `done_o` are low.
- R2: The start request is sampled at clock edge E0 with a valid index. At E1 the selected word sets bit1, at E2 it sets bit5, at E3 it clears bit6, and at E4 the core's bit in `l1_req_o` goes high.
- R3: While the selected core's `l1_ack_i` bit is low after E4, the selected word holds its value and `busy_o` stays high.
- R4: If the acknowledge is first sampled high at edge Ek, the word clears bit0 at Ek+1, sets bit4 at Ek+2, clears bit2 at Ek+3 and clears bit3 at Ek+4.
- R5: The sequence finishes only on an edge at or after Ek+5 where bit (index+9) is low in both `stat_a_i` and `stat_b_i`. That is bit 10, 11 or 12 for cores 1 to 3. If only one vector reports low, the block keeps waiting.
- R6: On the finishing edge `done_o` goes high for exactly one cycle and `busy_o` falls. The finished core's word is 0x32 and its cache request stays high.
- R7: A start with an index outside 1..NUM_CORES-1 (index 0 by default) leaves `busy_o` low, produces no done pulse, and changes no word and no request.
- R8: A start while `busy_o` is high is ignored. The running sequence is unaffected and the core named by the ignored start keeps its word.
- R9: A sequence changes only the selected core's word and request. Every other core keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Single-cycle request to power down a core |
| core_sel_i | input | IDX_W (2) | Index of the core to power down |
| l1_ack_i | input | NUM_CORES (4) | Per-core cache power-down acknowledge |
| stat_a_i | input | STAT_W (16) | Primary power-status vector |
| stat_b_i | input | STAT_W (16) | Secondary power-status vector |
| ctrl_o | output | NUM_CORES*7 (28) | Flattened per-core control words, core c at bits [7c+6:7c] |
| l1_req_o | output | NUM_CORES (4) | Per-core cache power-down request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench follows the selected word edge by edge with the acknowledge delayed by 0 to 20 cycles. A design that skipped the acknowledge wait, or reordered the reset and switch steps, would show a wrong word at some cycle of that trace. One run holds only the primary status low. A design that checked just one vector would finish too early there. Other runs start core 0 or inject a second start mid-sequence, where a careless design would wake up or switch cores and return a second done pulse. The completion cycle is checked exactly for several ack and status delays, so a done pulse one cycle early or late is caught.

// File: rtl/core_pdn_pkg.sv
package core_pdn_pkg;

  localparam int CTRL_W = 7;

  // bit positions inside a core's control word
  localparam int B_RSTN    = 0;
  localparam int B_ISO     = 1;
  localparam int B_SW1     = 2;
  localparam int B_SW2     = 3;
  localparam int B_CKOFF   = 4;
  localparam int B_SRCKISO = 5;
  localparam int B_SRISOB  = 6;

  localparam logic [CTRL_W-1:0] CTRL_RESET =
    CTRL_W'((1 << B_RSTN) | (1 << B_SW1) | (1 << B_SW2) | (1 << B_SRISOB));

  typedef enum logic [3:0] {
    ST_IDLE, ST_ISO, ST_CKISO, ST_SRAM, ST_L1REQ, ST_ACKWAIT,
    ST_RST, ST_CLKOFF, ST_SW1, ST_SW2, ST_STATWAIT
  } seq_st_e;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_ISO, ACT_CKISO, ACT_SRAMOFF, ACT_L1,
    ACT_RST, ACT_CLKOFF, ACT_SW1OFF, ACT_SW2OFF
  } act_e;

  function automatic logic [CTRL_W-1:0] apply_step(input logic [CTRL_W-1:0] w,
                                                   input act_e op);
    logic [CTRL_W-1:0] r;
    r = w;
    case (op)
      ACT_ISO:     r[B_ISO]     = 1'b1;
      ACT_CKISO:   r[B_SRCKISO] = 1'b1;
      ACT_SRAMOFF: r[B_SRISOB]  = 1'b0;
      ACT_RST:     r[B_RSTN]    = 1'b0;
      ACT_CLKOFF:  r[B_CKOFF]   = 1'b1;
      ACT_SW1OFF:  r[B_SW1]     = 1'b0;
      ACT_SW2OFF:  r[B_SW2]     = 1'b0;
      default:     r = w;
    endcase
    return r;
  endfunction

  function automatic logic idx_valid(input int idx, input int first, input int ncores);
    return (idx >= first) && (idx < ncores);
  endfunction

  function automatic int stat_bit(input int idx, input int base);
    return idx + base;
  endfunction

endpackage

// File: rtl/cpd_fsm.sv
module cpd_fsm
  import core_pdn_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int FIRST_CORE = 1,
  localparam int IDX_W     = $clog2(NUM_CORES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] core_sel_i,
  input  logic             ack_sel,
  input  logic             stat_clear_sel,
  output logic [IDX_W-1:0] cur_core,
  output act_e             step_op,
  output logic             idx_ok,
  output logic             in_ack_wait,
  output logic             in_stat_wait,
  output logic             busy_o,
  output logic             done_o
);

  seq_st_e st_q, st_d;
  logic    accept;

  assign idx_ok       = idx_valid(int'(core_sel_i), FIRST_CORE, NUM_CORES);
  assign accept       = start_i && idx_ok && (st_q == ST_IDLE);
  assign in_ack_wait  = (st_q == ST_ACKWAIT);
  assign in_stat_wait = (st_q == ST_STATWAIT);
  assign busy_o       = (st_q != ST_IDLE);

  always_comb begin
    st_d    = st_q;
    step_op = ACT_NONE;
    case (st_q)
      ST_IDLE:     if (accept) st_d = ST_ISO;
      ST_ISO:      begin step_op = ACT_ISO;     st_d = ST_CKISO;   end
      ST_CKISO:    begin step_op = ACT_CKISO;   st_d = ST_SRAM;    end
      ST_SRAM:     begin step_op = ACT_SRAMOFF; st_d = ST_L1REQ;   end
      ST_L1REQ:    begin step_op = ACT_L1;      st_d = ST_ACKWAIT; end
      ST_ACKWAIT:  if (ack_sel) st_d = ST_RST;
      ST_RST:      begin step_op = ACT_RST;     st_d = ST_CLKOFF;  end
      ST_CLKOFF:   begin step_op = ACT_CLKOFF;  st_d = ST_SW1;     end
      ST_SW1:      begin step_op = ACT_SW1OFF;  st_d = ST_SW2;     end
      ST_SW2:      begin step_op = ACT_SW2OFF;  st_d = ST_STATWAIT; end
      ST_STATWAIT: if (stat_clear_sel) st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cur_core <= '0;
      done_o   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= in_stat_wait && stat_clear_sel;
      if (accept) cur_core <= core_sel_i;
    end
  end

endmodule

// File: rtl/cpd_word_bank.sv
module cpd_word_bank
  import core_pdn_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W    = $clog2(NUM_CORES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            cur_core,
  input  act_e                        step_op,
  output logic [NUM_CORES*CTRL_W-1:0] ctrl_o,
  output logic [NUM_CORES-1:0]        l1_req_o
);

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic [CTRL_W-1:0] word_q;
    logic              req_q;
    logic              hit;

    assign hit = (cur_core == IDX_W'(g)) && (step_op != ACT_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= CTRL_RESET;
        req_q  <= 1'b0;
      end else if (hit) begin
        word_q <= apply_step(word_q, step_op);
        if (step_op == ACT_L1) req_q <= 1'b1;
      end
    end

    assign ctrl_o[g*CTRL_W +: CTRL_W] = word_q;
    assign l1_req_o[g]                = req_q;
  end

endmodule

// File: rtl/cpd_fb_sel.sv
module cpd_fb_sel
  import core_pdn_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int STAT_W    = 16,
  parameter int STAT_BASE = 9,
  localparam int IDX_W    = $clog2(NUM_CORES)
) (
  input  logic [IDX_W-1:0]            cur_core,
  input  logic [NUM_CORES-1:0]        l1_ack_i,
  input  logic [STAT_W-1:0]           stat_a_i,
  input  logic [STAT_W-1:0]           stat_b_i,
  input  logic [NUM_CORES*CTRL_W-1:0] ctrl_flat,
  output logic                        ack_sel,
  output logic                        stat_clear_sel,
  output logic [CTRL_W-1:0]           word_sel
);

  always_comb begin
    int   sb;
    logic a_on, b_on;
    sb       = stat_bit(int'(cur_core), STAT_BASE);
    a_on     = 1'b0;
    b_on     = 1'b0;
    ack_sel  = 1'b0;
    word_sel = '0;
    for (int i = 0; i < STAT_W; i++) begin
      if (i == sb) begin
        a_on = stat_a_i[i];
        b_on = stat_b_i[i];
      end
    end
    for (int c = 0; c < NUM_CORES; c++) begin
      if (c == int'(cur_core)) begin
        ack_sel  = l1_ack_i[c];
        word_sel = ctrl_flat[c*CTRL_W +: CTRL_W];
      end
    end
    stat_clear_sel = !a_on && !b_on;
  end

endmodule

// File: rtl/core_pdn_seq.sv
module core_pdn_seq
  import core_pdn_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int FIRST_CORE = 1,
  parameter int STAT_W     = 16,
  parameter int STAT_BASE  = 9,
  localparam int IDX_W     = $clog2(NUM_CORES),
  localparam int WORDS_W   = NUM_CORES * CTRL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [IDX_W-1:0]     core_sel_i,
  input  logic [NUM_CORES-1:0] l1_ack_i,
  input  logic [STAT_W-1:0]    stat_a_i,
  input  logic [STAT_W-1:0]    stat_b_i,
  output logic [WORDS_W-1:0]   ctrl_o,
  output logic [NUM_CORES-1:0] l1_req_o,
  output logic                 busy_o,
  output logic                 done_o
);

  // named internal events, also observed by the bound checker
  logic [IDX_W-1:0]  cur_core;
  act_e              step_op;
  logic              idx_ok;
  logic              in_ack_wait;
  logic              in_stat_wait;
  logic              ack_sel;
  logic              stat_clear_sel;
  logic [CTRL_W-1:0] word_sel;

  cpd_fsm #(.NUM_CORES(NUM_CORES), .FIRST_CORE(FIRST_CORE)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .core_sel_i     (core_sel_i),
    .ack_sel        (ack_sel),
    .stat_clear_sel (stat_clear_sel),
    .cur_core       (cur_core),
    .step_op        (step_op),
    .idx_ok         (idx_ok),
    .in_ack_wait    (in_ack_wait),
    .in_stat_wait   (in_stat_wait),
    .busy_o         (busy_o),
    .done_o         (done_o)
  );

  cpd_word_bank #(.NUM_CORES(NUM_CORES)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_core (cur_core),
    .step_op  (step_op),
    .ctrl_o   (ctrl_o),
    .l1_req_o (l1_req_o)
  );

  cpd_fb_sel #(.NUM_CORES(NUM_CORES), .STAT_W(STAT_W), .STAT_BASE(STAT_BASE)) u_fb (
    .cur_core       (cur_core),
    .l1_ack_i       (l1_ack_i),
    .stat_a_i       (stat_a_i),
    .stat_b_i       (stat_b_i),
    .ctrl_flat      (ctrl_o),
    .ack_sel        (ack_sel),
    .stat_clear_sel (stat_clear_sel),
    .word_sel       (word_sel)
  );

endmodule

// File: rtl/core_pdn_seq_chk.sv
module core_pdn_seq_chk #(
  parameter int IDX_W  = 2,
  parameter int CTRL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              idx_ok,
  input logic              busy_o,
  input logic              done_o,
  input logic              in_ack_wait,
  input logic              in_stat_wait,
  input logic              ack_sel,
  input logic              stat_clear_sel,
  input logic [IDX_W-1:0]  cur_core,
  input logic [CTRL_W-1:0] word_sel
);

  // R3
  ack_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack_wait && !ack_sel |=> in_ack_wait && $stable(word_sel));

  // R5
  rail_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_stat_wait && !stat_clear_sel |=> in_stat_wait && busy_o);

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(in_stat_wait) && $past(stat_clear_sel));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o ##1 !done_o);

  // R7
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !idx_ok && !busy_o |=> !busy_o);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(cur_core));

endmodule

bind core_pdn_seq core_pdn_seq_chk #(.IDX_W(IDX_W), .CTRL_W(core_pdn_pkg::CTRL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .idx_ok         (idx_ok),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .in_ack_wait    (in_ack_wait),
  .in_stat_wait   (in_stat_wait),
  .ack_sel        (ack_sel),
  .stat_clear_sel (stat_clear_sel),
  .cur_core       (cur_core),
  .word_sel       (word_sel)
);

// File: tb/core_pdn_seq_tb.sv
`timescale 1ns/1ps
module core_pdn_seq_tb;

  localparam int NC = 4;
  localparam int CW = 7;
  localparam logic [CW-1:0] W_UP   = 7'h4D;
  localparam logic [CW-1:0] W_DOWN = 7'h32;

  // vectors: core, ack delay, rail A delay, rail B delay, expected done cycle
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{1, 0,  0, 0, 10},
    '{2, 3,  2, 5, 18},
    '{3, 7,  4, 1, 21},
    '{1, 12, 0, 9, 31},
    '{3, 0,  6, 6, 16},
    '{2, 1,  0, 0, 11}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [1:0]    sel;
  logic [NC-1:0] l1_ack;
  logic [15:0]   stat_a, stat_b;
  logic [NC*CW-1:0] ctrl;
  logic [NC-1:0] l1_req;
  logic          busy, done;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  core_pdn_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .core_sel_i(sel),
    .l1_ack_i(l1_ack), .stat_a_i(stat_a), .stat_b_i(stat_b),
    .ctrl_o(ctrl), .l1_req_o(l1_req), .busy_o(busy), .done_o(done)
  );

  function automatic logic [CW-1:0] word_of(input int c);
    return ctrl[c*CW +: CW];
  endfunction

  // expected word c cycles after the start edge, ack sampled at edge 5+a
  function automatic logic [CW-1:0] exp_word(input int c, input int a);
    logic [CW-1:0] w;
    w = W_UP;
    if (c >= 1)     w = w | 7'h02;
    if (c >= 2)     w = w | 7'h20;
    if (c >= 3)     w = w & ~7'h40;
    if (c >= 6 + a) w = w & ~7'h01;
    if (c >= 7 + a) w = w | 7'h10;
    if (c >= 8 + a) w = w & ~7'h04;
    if (c >= 9 + a) w = w & ~7'h08;
    return w;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    start  = 1'b0;
    sel    = '0;
    l1_ack = '0;
    stat_a = 16'h1C00;
    stat_b = 16'h1C00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // sb < 0: rail B never cleared; inj_c < 0: no second start
  task automatic run_seq(input int core, input int a, input int sa, input int sb,
                         input int inj_c, input int inj_core, input int ncyc,
                         output int first_done, output int ndone, output int trace_err);
    first_done = -1;
    ndone      = 0;
    trace_err  = 0;
    sel   = 2'(core);
    start = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (first_done < 0) begin
        if (word_of(core) != exp_word(c, a)) trace_err++;
        if (l1_req[core] != (c >= 4)) trace_err++;
      end
      if (done) begin
        ndone++;
        if (first_done < 0) first_done = c;
      end
      if (c == 0) start = 1'b0;
      if (c == inj_c) begin start = 1'b1; sel = 2'(inj_core); end
      if (c == inj_c + 1) start = 1'b0;
      if (c == 4 + a) l1_ack[core] = 1'b1;
      if (c == 9 + a + sa) stat_a[core + 9] = 1'b0;
      if (sb >= 0 && c == 9 + a + sb) stat_b[core + 9] = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int fd, nd, te;

    // R1: reset state
    do_reset();
    for (int c = 0; c < NC; c++)
      check(word_of(c) == W_UP, "R1 reset word", int'(word_of(c)), int'(W_UP));
    check(l1_req == '0 && !busy && !done, "R1 reset flags",
          int'({l1_req, busy, done}), 0);

    // table-driven sequences: R2 R4 trace, R5 R6 timing, R9 neighbours
    for (int v = 0; v < NV; v++) begin
      do_reset();
      run_seq(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], -1, 0, 40, fd, nd, te);
      check(te == 0, "R2/R4 step trace", te, 0);
      check(fd == VEC[v][4], "R5 done cycle", fd, VEC[v][4]);
      check(nd == 1, "R6 single done", nd, 1);
      check(word_of(VEC[v][0]) == W_DOWN && l1_req[VEC[v][0]] && !busy,
            "R6 final word", int'(word_of(VEC[v][0])), int'(W_DOWN));
      for (int c = 0; c < NC; c++)
        if (c != VEC[v][0])
          check(word_of(c) == W_UP && !l1_req[c], "R9 other core",
                int'(word_of(c)), int'(W_UP));
    end

    // R3: long ack stall with word held and busy high
    do_reset();
    run_seq(2, 0, 0, 0, -1, 0, 0, fd, nd, te);
    sel = 2'd2; start = 1'b1;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      if (c == 0) start = 1'b0;
    end
    check(word_of(2) == 7'h2F && busy && l1_req[2], "R3 stall word",
          int'(word_of(2)), 'h2F);
    l1_ack[2] = 1'b1;
    repeat (5) @(negedge clk);
    check(word_of(2) == W_DOWN && busy, "R4 after ack", int'(word_of(2)), int'(W_DOWN));

    // R5: only rail A clear keeps waiting, then rail B finishes it
    do_reset();
    run_seq(3, 0, 0, -1, -1, 0, 40, fd, nd, te);
    check(fd == -1 && busy, "R5 one rail waits", fd, -1);
    stat_b[12] = 1'b0;
    @(negedge clk);
    check(done && !busy, "R5 both rails done", int'(done), 1);
    @(negedge clk);
    check(!done, "R6 pulse width", int'(done), 0);

    // R7: index 0 ignored
    do_reset();
    sel = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nd = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (done || busy) nd++;
    end
    check(nd == 0, "R7 no activity", nd, 0);
    check(word_of(0) == W_UP && l1_req == '0, "R7 words kept", int'(word_of(0)), int'(W_UP));

    // R8: start for core 3 while core 1 runs
    do_reset();
    run_seq(1, 2, 1, 1, 3, 3, 40, fd, nd, te);
    check(te == 0 && fd == 13 && nd == 1, "R8 run unaffected", fd, 13);
    check(word_of(3) == W_UP && !l1_req[3], "R8 injected core kept",
          int'(word_of(3)), int'(W_UP));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule